// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller with Busy Polling

This block sits in front of a modelled nonvolatile program store and a byte-wide data store and sequences every write into them. Program memory is written a page at a time. A page holds 64 words of 16 bits. Software fills a staging buffer one word at a time, giving each word's low byte first and its high byte second. A commit strobe then writes the whole buffer into the page that the upper bits of the word address select. Data memory is written one byte at a time. Each new byte fully replaces the old one, as if the cell had been erased just before the write.

Both kinds of write are followed by a busy period. Its length in clock cycles comes from an input, so simulations can use short delays. During a page write, reading any word of that page returns all ones. During a byte write, reading that byte returns 0xFF. Software can therefore poll a location until its real value appears. A value of 0xFF cannot be confirmed this way, so in that case the caller waits out the programmed time or watches the busy outputs. Any write request made while either store is busy is dropped, and a sticky error flag is set.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset, progBusy, dataBusy, errFlag and rdValid are low. Every program word reads 0xFFFF and every data byte reads 0xFF. Every staging-buffer word is 0xFFFF.
- R2: loadLo keeps loadByte as the pending low byte. The following loadHi writes the word {loadByte, pending low} into the buffer slot progAddr[5:0]. Only the most recent loadLo counts. A loadHi with no accepted loadLo since the last accepted loadHi (or since reset) is ignored and sets errFlag.
- R3: An accepted commit copies all 64 buffer words into the page progAddr[PAGE_W+5:6]. progBusy is high for exactly pageTime cycles, starting the cycle after the commit. Every buffer word then returns to 0xFFFF, so buffer slots not loaded before the next commit write 0xFFFF.
- R4: While progBusy is high, a program read of any word in the page being written returns 0xFFFF. Reads of other pages return their stored content.
- R5: An accepted byteWr makes dataBusy high for exactly byteTime cycles, starting the next cycle. While dataBusy is high, a read of that byte returns 0xFF.
- R6: Once busy ends, a read returns the written value. A byte write replaces the previous content completely: writing 0x0F over 0xF0 reads back as 0x0F. Writing 0xFF reads 0xFF both during the busy period and after it.
- R7: While progBusy or dataBusy is high, loadLo, loadHi, commit and byteWr are ignored and set errFlag. errFlag stays high until reset. The two busy flags are never high together.
- R8: A read strobe (rdProg for program address progAddr, rdDmem for data address dataAddr) gives rdValid high and the result on rdData in the following cycle. Data results are zero-extended as {8'h00, byte}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageTime | input | CNT_W | Busy length of a page write, in cycles |
| byteTime | input | CNT_W | Busy length of a byte write, in cycles |
| progAddr | input | PAGE_W+6 | Program word address: low 6 bits pick the buffer slot, high bits pick the page |
| loadByte | input | 8 | Byte for loadLo or loadHi |
| loadLo | input | 1 | Stage a low byte |
| loadHi | input | 1 | Supply the high byte and write the word into the buffer |
| commit | input | 1 | Write the buffer into the addressed page |
| dataAddr | input | DA_W | Data-memory byte address for writes and reads |
| dataByte | input | 8 | Byte to write into data memory |
| byteWr | input | 1 | Start a data-memory byte write |
| rdProg | input | 1 | Read the program word at progAddr |
| rdDmem | input | 1 | Read the data byte at dataAddr |
| rdData | output | 16 | Read result, one cycle after the strobe |
| rdValid | output | 1 | rdData holds a fresh result |
| progBusy | output | 1 | Page write in progress |
| dataBusy | output | 1 | Byte write in progress |
| errFlag | output | 1 | Sticky: a request was rejected |

## Verification
The properties assume that at most one of the strobes loadLo, loadHi, commit, byteWr, rdProg and rdDmem is high in any cycle. They also assume pageTime and byteTime are at least 1, because a commit or byte write that is accepted is expected to raise its busy flag. The bench drives one strobe per cycle. Its random delays are drawn from 3 to 20 cycles for pages and 2 to 9 cycles for bytes. Because of this floor, the first read after a write still falls inside the busy window.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;

  // Strobes the control issues to the storage datapath, already qualified
  typedef struct packed {
    logic bufLo;   // capture pending low byte
    logic bufHi;   // write {high, pending low} into buffer slot
    logic pageWr;  // copy buffer into a page, then clear buffer
    logic byteWr;  // write one data byte
  } ctrlStrobe_t;

endpackage

// File: rtl/prog_ctrl.sv
module prog_ctrl
  import page_prog_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PAGE_W = 4,
  parameter int DA_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  pageTime,
  input  logic [CNT_W-1:0]  byteTime,
  input  logic              loadLo,
  input  logic              loadHi,
  input  logic              commit,
  input  logic              byteWr,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic [DA_W-1:0]   dataAddr,
  output ctrlStrobe_t       strobe,
  output logic              progBusy,
  output logic              dataBusy,
  output logic [PAGE_W-1:0] busyPage,
  output logic [DA_W-1:0]   busyByte,
  output logic              errFlag
);

  logic [CNT_W-1:0] pageCnt;
  logic [CNT_W-1:0] byteCnt;
  logic             loPending;
  logic             anyBusy;
  logic             reqAny;
  logic             errSet;

  assign progBusy = (pageCnt != '0);
  assign dataBusy = (byteCnt != '0);

  always_comb begin
    anyBusy       = progBusy | dataBusy;
    reqAny        = loadLo | loadHi | commit | byteWr;
    strobe.bufLo  = loadLo & ~anyBusy;
    strobe.bufHi  = loadHi & ~anyBusy & loPending;
    strobe.pageWr = commit & ~anyBusy;
    strobe.byteWr = byteWr & ~anyBusy;
    errSet        = (reqAny & anyBusy) | (loadHi & ~anyBusy & ~loPending);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageCnt   <= '0;
      byteCnt   <= '0;
      busyPage  <= '0;
      busyByte  <= '0;
      loPending <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (strobe.pageWr) begin
        pageCnt  <= pageTime;
        busyPage <= pageSel;
      end else if (progBusy) begin
        pageCnt <= pageCnt - 1'b1;
      end

      if (strobe.byteWr) begin
        byteCnt  <= byteTime;
        busyByte <= dataAddr;
      end else if (dataBusy) begin
        byteCnt <= byteCnt - 1'b1;
      end

      if (strobe.bufLo)      loPending <= 1'b1;
      else if (strobe.bufHi) loPending <= 1'b0;

      if (errSet) errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/prog_datapath.sv
module prog_datapath
  import page_prog_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int IDX_W  = 6,
  parameter int DA_W   = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [PAGE_W+IDX_W-1:0] progAddr,
  input  logic [7:0]              loadByte,
  input  logic [DA_W-1:0]         dataAddr,
  input  logic [7:0]              dataByte,
  input  logic                    rdProg,
  input  logic                    rdDmem,
  input  logic                    progBusy,
  input  logic                    dataBusy,
  input  logic [PAGE_W-1:0]       busyPage,
  input  logic [DA_W-1:0]         busyByte,
  output logic [15:0]             rdData,
  output logic                    rdValid
);

  localparam int WORDS  = 1 << IDX_W;
  localparam int MA_W   = PAGE_W + IDX_W;
  localparam int PWORDS = 1 << MA_W;
  localparam int DBYTES = 1 << DA_W;

  logic [15:0] pageBuf [WORDS];
  logic [15:0] progMem [PWORDS];
  logic [7:0]  dataMem [DBYTES];
  logic [7:0]  loStage;

  logic [IDX_W-1:0]  slot;
  logic [PAGE_W-1:0] page;

  assign slot = progAddr[IDX_W-1:0];
  assign page = progAddr[IDX_W +: PAGE_W];

  // Staging buffer: erased after reset and after every page commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loStage <= 8'hFF;
      for (int i = 0; i < WORDS; i++) pageBuf[i] <= 16'hFFFF;
    end else if (strobe.pageWr) begin
      for (int i = 0; i < WORDS; i++) pageBuf[i] <= 16'hFFFF;
    end else begin
      if (strobe.bufLo) loStage <= loadByte;
      if (strobe.bufHi) pageBuf[slot] <= {loadByte, loStage};
    end
  end

  // Storage arrays: whole page in one step, data byte overwrites fully
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PWORDS; i++) progMem[i] <= 16'hFFFF;
      for (int i = 0; i < DBYTES; i++) dataMem[i] <= 8'hFF;
    end else begin
      if (strobe.pageWr)
        for (int i = 0; i < WORDS; i++)
          progMem[{page, IDX_W'(i)}] <= pageBuf[i];
      if (strobe.byteWr) dataMem[dataAddr] <= dataByte;
    end
  end

  // Read port with polling mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdProg | rdDmem;
      if (rdProg)
        rdData <= (progBusy && page == busyPage) ? 16'hFFFF : progMem[progAddr];
      else if (rdDmem)
        rdData <= {8'h00, (dataBusy && dataAddr == busyByte) ? 8'hFF : dataMem[dataAddr]};
    end
  end

endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl
  import page_prog_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PAGE_W = 4,
  parameter int DA_W   = 6,
  localparam int IDX_W = 6,
  localparam int PA_W  = PAGE_W + IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pageTime,
  input  logic [CNT_W-1:0] byteTime,
  input  logic [PA_W-1:0]  progAddr,
  input  logic [7:0]       loadByte,
  input  logic             loadLo,
  input  logic             loadHi,
  input  logic             commit,
  input  logic [DA_W-1:0]  dataAddr,
  input  logic [7:0]       dataByte,
  input  logic             byteWr,
  input  logic             rdProg,
  input  logic             rdDmem,
  output logic [15:0]      rdData,
  output logic             rdValid,
  output logic             progBusy,
  output logic             dataBusy,
  output logic             errFlag
);

  ctrlStrobe_t       strobe;
  logic [PAGE_W-1:0] busyPage;
  logic [DA_W-1:0]   busyByte;

  prog_ctrl #(.CNT_W(CNT_W), .PAGE_W(PAGE_W), .DA_W(DA_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pageTime (pageTime),
    .byteTime (byteTime),
    .loadLo   (loadLo),
    .loadHi   (loadHi),
    .commit   (commit),
    .byteWr   (byteWr),
    .pageSel  (progAddr[IDX_W +: PAGE_W]),
    .dataAddr (dataAddr),
    .strobe   (strobe),
    .progBusy (progBusy),
    .dataBusy (dataBusy),
    .busyPage (busyPage),
    .busyByte (busyByte),
    .errFlag  (errFlag)
  );

  prog_datapath #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .DA_W(DA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .progAddr (progAddr),
    .loadByte (loadByte),
    .dataAddr (dataAddr),
    .dataByte (dataByte),
    .rdProg   (rdProg),
    .rdDmem   (rdDmem),
    .progBusy (progBusy),
    .dataBusy (dataBusy),
    .busyPage (busyPage),
    .busyByte (busyByte),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/page_prog_checker.sv
module page_prog_checker #(
  parameter int PAGE_W = 4,
  parameter int PA_W   = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [PA_W-1:0]   progAddr,
  input logic              loadLo,
  input logic              loadHi,
  input logic              commit,
  input logic              byteWr,
  input logic              rdProg,
  input logic              rdDmem,
  input logic [15:0]       rdData,
  input logic              rdValid,
  input logic              progBusy,
  input logic              dataBusy,
  input logic              errFlag,
  input logic [PAGE_W-1:0] busyPage
);

  p_mask_busy_page_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdProg && progBusy && progAddr[PA_W-1 -: PAGE_W] == busyPage) |=> (rdData == 16'hFFFF));

  p_commit_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !progBusy && !dataBusy) |=> progBusy);

  p_byte_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && !progBusy && !dataBusy) |=> dataBusy);

  p_reject_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((loadLo || loadHi || commit || byteWr) && (progBusy || dataBusy)) |=> errFlag);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_busy_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(progBusy && dataBusy));

  p_read_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdProg || rdDmem) |=> rdValid);

  p_data_zext_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdDmem && !rdProg) |=> (rdData[15:8] == 8'h00));

endmodule

bind page_prog_ctrl page_prog_checker #(.PAGE_W(PAGE_W), .PA_W(PA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .progAddr (progAddr),
  .loadLo   (loadLo),
  .loadHi   (loadHi),
  .commit   (commit),
  .byteWr   (byteWr),
  .rdProg   (rdProg),
  .rdDmem   (rdDmem),
  .rdData   (rdData),
  .rdValid  (rdValid),
  .progBusy (progBusy),
  .dataBusy (dataBusy),
  .errFlag  (errFlag),
  .busyPage (busyPage)
);

// File: tb/test_page_prog_ctrl.sv
module test_page_prog_ctrl;

  localparam int CNT_W  = 12;
  localparam int PAGE_W = 4;
  localparam int DA_W   = 6;
  localparam int PA_W   = PAGE_W + 6;
  localparam int NPW    = 1 << PA_W;
  localparam int NDB    = 1 << DA_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] pageTime = 12'd10;
  logic [CNT_W-1:0] byteTime = 12'd6;
  logic [PA_W-1:0]  progAddr = '0;
  logic [7:0]       loadByte = '0;
  logic             loadLo = 1'b0, loadHi = 1'b0, commit = 1'b0;
  logic [DA_W-1:0]  dataAddr = '0;
  logic [7:0]       dataByte = '0;
  logic             byteWr = 1'b0, rdProg = 1'b0, rdDmem = 1'b0;
  logic [15:0]      rdData;
  logic             rdValid, progBusy, dataBusy, errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] expProg [NPW];
  logic [7:0]  expData [NDB];
  logic [15:0] expBuf  [64];

  always #5 clk = ~clk;

  page_prog_ctrl #(.CNT_W(CNT_W), .PAGE_W(PAGE_W), .DA_W(DA_W)) i_page_prog_ctrl (
    .clk(clk), .rstN(rstN), .pageTime(pageTime), .byteTime(byteTime),
    .progAddr(progAddr), .loadByte(loadByte), .loadLo(loadLo), .loadHi(loadHi),
    .commit(commit), .dataAddr(dataAddr), .dataByte(dataByte), .byteWr(byteWr),
    .rdProg(rdProg), .rdDmem(rdDmem), .rdData(rdData), .rdValid(rdValid),
    .progBusy(progBusy), .dataBusy(dataBusy), .errFlag(errFlag)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [PA_W-1:0] wa(int pg, int idx);
    return {PAGE_W'(pg), 6'(idx)};
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NPW; i++) expProg[i] = 16'hFFFF;
    for (int i = 0; i < NDB; i++) expData[i] = 8'hFF;
    for (int i = 0; i < 64; i++)  expBuf[i]  = 16'hFFFF;
  endtask

  task automatic modelCommit(int pg);
    for (int i = 0; i < 64; i++) begin
      expProg[wa(pg, i)] = expBuf[i];
      expBuf[i] = 16'hFFFF;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic strobeLo(int idx, logic [7:0] b);
    progAddr = wa(0, idx); loadByte = b; loadLo = 1'b1; tick(); loadLo = 1'b0;
  endtask

  task automatic strobeHi(int idx, logic [7:0] b);
    progAddr = wa(0, idx); loadByte = b; loadHi = 1'b1; tick(); loadHi = 1'b0;
  endtask

  task automatic loadWord(int idx, logic [15:0] w);
    strobeLo(idx, w[7:0]);
    strobeHi(idx, w[15:8]);
  endtask

  task automatic doCommit(int pg);
    progAddr = wa(pg, 0); commit = 1'b1; tick(); commit = 1'b0;
  endtask

  task automatic doByte(int a, logic [7:0] b);
    dataAddr = DA_W'(a); dataByte = b; byteWr = 1'b1; tick(); byteWr = 1'b0;
  endtask

  task automatic readProg(logic [PA_W-1:0] a, output logic [15:0] v);
    progAddr = a; rdProg = 1'b1; tick(); rdProg = 1'b0;
    v = rdData;
    check("R8", "rdValid after program read", 32'(rdValid), 32'd1);
  endtask

  task automatic readData(int a, output logic [15:0] v);
    dataAddr = DA_W'(a); rdDmem = 1'b1; tick(); rdDmem = 1'b0;
    v = rdData;
    check("R8", "rdValid after data read", 32'(rdValid), 32'd1);
  endtask

  task automatic waitIdle();
    while (progBusy || dataBusy) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'd24681));
    modelReset();
    @(negedge clk);
    doReset();

    // R1: reset state
    check("R1", "progBusy after reset", 32'(progBusy), 0);
    check("R1", "dataBusy after reset", 32'(dataBusy), 0);
    check("R1", "errFlag after reset", 32'(errFlag), 0);
    check("R1", "rdValid after reset", 32'(rdValid), 0);
    readProg(wa(9, 33), v);  check("R1", "erased program word", 32'(v), 32'hFFFF);
    readData(17, v);         check("R1", "erased data byte", 32'(v), 32'h00FF);

    // R2/R3/R4: directed page write
    pageTime = 12'd10;
    loadWord(5, 16'hA55A);  expBuf[5]  = 16'hA55A;
    loadWord(63, 16'h1234); expBuf[63] = 16'h1234;
    doCommit(3); modelCommit(3);
    readProg(wa(3, 5), v);  check("R4", "masked word in busy page", 32'(v), 32'hFFFF);
    waitIdle();
    readProg(wa(3, 5), v);  check("R3", "page word 5 after commit", 32'(v), 32'hA55A);
    readProg(wa(3, 63), v); check("R2", "slot 63 word order", 32'(v), 32'h1234);
    readProg(wa(3, 0), v);  check("R3", "unloaded slot erased", 32'(v), 32'hFFFF);

    // R3: busy length
    pageTime = 12'd13;
    loadWord(1, 16'h0102); expBuf[1] = 16'h0102;
    doCommit(7); modelCommit(7);
    n = 0;
    while (progBusy) begin n++; tick(); end
    check("R3", "page busy cycles", 32'(n), 32'd13);
    readProg(wa(7, 1), v); check("R3", "page 7 word 1", 32'(v), 32'h0102);

    // R4: other pages readable, any address of busy page masked
    loadWord(9, 16'h5555); expBuf[9] = 16'h5555;
    doCommit(4); modelCommit(4);
    readProg(wa(3, 5), v);  check("R4", "other page during busy", 32'(v), 32'hA55A);
    readProg(wa(4, 20), v); check("R4", "unrelated slot of busy page", 32'(v), 32'hFFFF);
    waitIdle();

    // R3: buffer erased after commit
    doCommit(3); modelCommit(3);
    waitIdle();
    readProg(wa(3, 5), v); check("R3", "buffer cleared after commit", 32'(v), 32'hFFFF);

    // R2: only the latest low byte counts
    strobeLo(12, 8'h11); strobeLo(12, 8'h22); strobeHi(12, 8'h33);
    expBuf[12] = 16'h3322;
    doCommit(6); modelCommit(6); waitIdle();
    readProg(wa(6, 12), v); check("R2", "latest low byte used", 32'(v), 32'h3322);
    check("R2", "no error on ordered load", 32'(errFlag), 0);

    // R5/R6: byte writes
    byteTime = 12'd6;
    doByte(11, 8'h33); expData[11] = 8'h33; waitIdle();
    doByte(10, 8'hF0); expData[10] = 8'hF0;
    n = 0;
    while (dataBusy) begin n++; tick(); end
    check("R5", "byte busy cycles", 32'(n), 32'd6);
    readData(10, v); check("R6", "byte readback", 32'(v), 32'h00F0);
    doByte(10, 8'h0F); expData[10] = 8'h0F;
    readData(10, v); check("R5", "busy byte masked", 32'(v), 32'h00FF);
    readData(11, v); check("R5", "neighbour byte during busy", 32'(v), 32'h0033);
    waitIdle();
    readData(10, v); check("R6", "overwrite replaces content", 32'(v), 32'h000F);
    doByte(12, 8'hFF); expData[12] = 8'hFF;
    readData(12, v); check("R6", "0xFF during busy", 32'(v), 32'h00FF);
    waitIdle();
    readData(12, v); check("R6", "0xFF after busy", 32'(v), 32'h00FF);

    // R7: requests during busy are dropped
    pageTime = 12'd20;
    loadWord(0, 16'hBEEF); expBuf[0] = 16'hBEEF;
    doCommit(8); modelCommit(8);
    check("R7", "busy exclusive", 32'(progBusy & dataBusy), 0);
    doCommit(9);
    loadWord(2, 16'h7777);
    doByte(20, 8'h44);
    check("R7", "errFlag after rejected requests", 32'(errFlag), 1);
    waitIdle();
    doCommit(10); modelCommit(10); waitIdle();
    readProg(wa(10, 2), v); check("R7", "ignored load not buffered", 32'(v), 32'hFFFF);
    readData(20, v);        check("R7", "ignored byte write", 32'(v), 32'h00FF);
    readProg(wa(8, 0), v);  check("R7", "accepted page intact", 32'(v), 32'hBEEF);
    tick();
    check("R7", "errFlag sticky", 32'(errFlag), 1);
    doReset();
    check("R7", "errFlag cleared by reset", 32'(errFlag), 0);

    // R2: high byte without low byte
    strobeHi(4, 8'h99);
    check("R2", "error on lone high byte", 32'(errFlag), 1);
    doCommit(1); modelCommit(1); waitIdle();
    readProg(wa(1, 4), v); check("R2", "lone high byte ignored", 32'(v), 32'hFFFF);
    doReset();

    // Random rounds
    for (int r = 0; r < 6; r++) begin
      int pg;
      pg = $urandom_range(15);
      pageTime = CNT_W'($urandom_range(20, 3));
      for (int k = 0; k < 8; k++) begin
        int idx;
        logic [15:0] w;
        idx = $urandom_range(63);
        w = 16'($urandom);
        loadWord(idx, w); expBuf[idx] = w;
      end
      doCommit(pg); modelCommit(pg);
      readProg(wa(pg, $urandom_range(63)), v);
      check("R4", "random busy page masked", 32'(v), 32'hFFFF);
      waitIdle();
      byteTime = CNT_W'($urandom_range(9, 2));
      for (int k = 0; k < 6; k++) begin
        int a;
        logic [7:0] b;
        a = $urandom_range(NDB - 1);
        b = 8'($urandom);
        doByte(a, b); expData[a] = b;
        readData(a, v); check("R5", "random byte masked", 32'(v), 32'h00FF);
        waitIdle();
        readData(a, v); check("R6", "random byte readback", 32'(v), 32'(b));
      end
    end

    // Final sweep against model
    for (int i = 0; i < NPW; i++) begin
      readProg(PA_W'(i), v);
      check("R3", "sweep program word", 32'(v), 32'(expProg[i]));
    end
    for (int i = 0; i < NDB; i++) begin
      readData(i, v);
      check("R6", "sweep data byte", 32'(v), 32'(expData[i]));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule